// File: doc/BRIEF.md
# Nibble RAM and Port Access Controller

This block sits beside a 4-bit accumulator datapath and carries out its data-memory and port commands. It keeps a 12-bit RAM address register. The low byte of that register is loaded from an 8-bit register pair. The top four bits are loaded from the accumulator. Every memory location is one byte, and it holds two 4-bit characters: the main character in the low nibble and one status character in the high nibble. Each write is a read-modify-write that leaves the other nibble of the byte unchanged.

A command is offered on `op_valid`/`op_code` and is taken on any clock edge where `busy` is low. Address loads and port writes finish in one cycle. Memory commands and the ROM-port read take two cycles: a read followed by a write or a result. `busy` stays high for the second of these cycles. Reads return a nibble on `res_data` together with a one-cycle `res_valid` pulse. Port traffic uses a registered 6-bit address and 4-bit data, with one-cycle strobes.

Top module: `nibble_mem_ctrl`

## Requirements
- R1: On reset the 12-bit address register `ram_addr` is 0, and `busy`, `res_valid`, `port_wr` and `port_rd` are low.
- R2: Command 0 (select) copies `op_pair` into `ram_addr[7:0]` on the accepting edge and keeps `ram_addr[11:8]`.
- R3: Command 1 (bank) copies `op_acc` into `ram_addr[11:8]` on the accepting edge and keeps `ram_addr[7:0]`.
- R4: Command 2 (main read) returns the low nibble of the byte at `ram_addr`. `res_valid` pulses in the cycle after the second edge counted from acceptance.
- R5: Command 3 (main write) replaces the low nibble of the byte at `ram_addr` with `op_acc` and keeps the high nibble.
- R6: Commands 4+n (status read, n = 0..3) return the high nibble of the byte at `{ram_addr[11:4], 4'h0} + n`.
- R7: Commands 8+n (status write, n = 0..3) replace the high nibble of the byte at `{ram_addr[11:4], 4'h0} + n` with `op_acc` and keep the low nibble.
- R8: Command 12 (output port write) pulses `port_wr` for one cycle. `port_addr` is `ram_addr[11:6] | 6'h10` and `port_wdata` is `op_acc`.
- R9: Command 13 (ROM-port read) pulses `port_rd` with `port_addr = {2'b00, ram_addr[7:4]}`. It then returns the `port_rdata` value seen during the following cycle as a result.
- R10: Command 14 (ROM-port write) pulses `port_wr` with `port_addr = {2'b00, ram_addr[7:4]}` and `port_wdata = op_acc`.
- R11: After a two-cycle command is accepted, `busy` is high for exactly one cycle. A command offered while `busy` is high is ignored and does not change `ram_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Command offered |
| op_code | input | 4 | Command code (see requirements) |
| op_pair | input | 8 | Register pair value for select |
| op_acc | input | 4 | Accumulator value |
| busy | output | 1 | Second cycle of a two-cycle command |
| res_valid | output | 1 | Result nibble valid |
| res_data | output | 4 | Result nibble for the accumulator |
| ram_addr | output | 12 | RAM address register |
| port_addr | output | 6 | Port bus address |
| port_wr | output | 1 | Port write strobe |
| port_rd | output | 1 | Port read strobe |
| port_wdata | output | 4 | Port write data |
| port_rdata | input | 4 | Port read data |

## Verification
The bench places main and status characters in the same bytes and interleaves writes to each nibble. A design that dropped the read half of the read-modify-write would then read back zeros or stale data in the neighbouring nibble. Status accesses are issued with a non-zero low address nibble. An index that added `n` to the full address instead of the masked one would then hit the wrong byte. The output-port address is checked for the forced tag bit and the six-bit shift, and the ROM-port address for the use of bits 7:4. A select offered during `busy` is checked to leave the address register untouched; a design that accepted it would move later accesses to another byte.

// File: rtl/nibble_mem_ctrl.sv
module nibble_mem_ctrl #(
  parameter int AW = 12,
  parameter int PW = 6,
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [3:0]    op_code,
  input  logic [2*NW-1:0] op_pair,
  input  logic [NW-1:0] op_acc,
  output logic          busy,
  output logic          res_valid,
  output logic [NW-1:0] res_data,
  output logic [AW-1:0] ram_addr,
  output logic [PW-1:0] port_addr,
  output logic          port_wr,
  output logic          port_rd,
  output logic [NW-1:0] port_wdata,
  input  logic [NW-1:0] port_rdata
);
  localparam int BW = 2 * NW;
  localparam int HW = AW - BW;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] OUT_TAG = PW'(1) << (PW - 2);

  logic [AW-1:0] addr_q, badr_q;
  logic [BW-1:0] mem [0:DEPTH-1];
  logic [BW-1:0] rd_q;
  logic [NW-1:0] wdat_q;
  logic          busy_q, wr_q, hi_q, rom_q;

  wire accept   = op_valid & ~busy_q;
  wire is_stat  = (op_code >= 4'd4) && (op_code <= 4'd11);
  wire is_memop = (op_code >= 4'd2) && (op_code <= 4'd11);
  wire is_write = (op_code == 4'd3) || (op_code >= 4'd8 && op_code <= 4'd11);
  wire [AW-1:0] stat_addr = {addr_q[AW-1:4], 2'b00, op_code[1:0]};
  wire [AW-1:0] tgt_addr  = is_stat ? stat_addr : addr_q;
  wire [PW-1:0] rom_port  = {{(PW-NW){1'b0}}, addr_q[BW-1:NW]};
  wire [BW-1:0] merged    = hi_q ? {wdat_q, rd_q[NW-1:0]} : {rd_q[BW-1:NW], wdat_q};

  assign busy     = busy_q;
  assign ram_addr = addr_q;

  always_ff @(posedge clk) begin
    if (accept && is_memop) rd_q <= mem[tgt_addr];
    if (busy_q && wr_q && !rom_q) mem[badr_q] <= merged;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q     <= '0;
      badr_q     <= '0;
      wdat_q     <= '0;
      busy_q     <= 1'b0;
      wr_q       <= 1'b0;
      hi_q       <= 1'b0;
      rom_q      <= 1'b0;
      res_valid  <= 1'b0;
      res_data   <= '0;
      port_addr  <= '0;
      port_wr    <= 1'b0;
      port_rd    <= 1'b0;
      port_wdata <= '0;
    end else begin
      port_wr   <= 1'b0;
      port_rd   <= 1'b0;
      res_valid <= 1'b0;
      if (busy_q) begin
        busy_q <= 1'b0;
        if (!wr_q) begin
          res_valid <= 1'b1;
          res_data  <= rom_q ? port_rdata : (hi_q ? rd_q[BW-1:NW] : rd_q[NW-1:0]);
        end
      end else if (accept) begin
        if (op_code == 4'd0) addr_q[BW-1:0] <= op_pair;
        if (op_code == 4'd1) addr_q[AW-1:BW] <= op_acc[HW-1:0];
        if (is_memop) begin
          busy_q <= 1'b1;
          wr_q   <= is_write;
          hi_q   <= is_stat;
          rom_q  <= 1'b0;
          badr_q <= tgt_addr;
          wdat_q <= op_acc;
        end
        if (op_code == 4'd12) begin
          port_wr    <= 1'b1;
          port_addr  <= addr_q[AW-1:AW-PW] | OUT_TAG;
          port_wdata <= op_acc;
        end
        if (op_code == 4'd13) begin
          port_rd   <= 1'b1;
          port_addr <= rom_port;
          busy_q    <= 1'b1;
          wr_q      <= 1'b0;
          rom_q     <= 1'b1;
        end
        if (op_code == 4'd14) begin
          port_wr    <= 1'b1;
          port_addr  <= rom_port;
          port_wdata <= op_acc;
        end
      end
    end
  end
endmodule

// File: rtl/nibble_mem_ctrl_chk.sv
module nibble_mem_ctrl_chk #(
  parameter int AW = 12,
  parameter int NW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [3:0]    op_code,
  input logic [2*NW-1:0] op_pair,
  input logic [NW-1:0] op_acc,
  input logic          busy,
  input logic          res_valid,
  input logic [AW-1:0] ram_addr,
  input logic          port_wr,
  input logic          port_rd
);
  localparam int BW = 2 * NW;

  assert_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && op_code == 4'd0) |=>
      (ram_addr[BW-1:0] == $past(op_pair) && ram_addr[AW-1:BW] == $past(ram_addr[AW-1:BW])));

  assert_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && op_code == 4'd1) |=>
      (ram_addr[AW-1:BW] == $past(op_acc[AW-BW-1:0]) && ram_addr[BW-1:0] == $past(ram_addr[BW-1:0])));

  assert_result_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(busy));

  assert_strobe_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({port_wr, port_rd, res_valid}));

  assert_busy_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  assert_busy_holds_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ram_addr));

  assert_memop_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && op_code >= 4'd2 && op_code <= 4'd11) |=> busy);
endmodule

bind nibble_mem_ctrl nibble_mem_ctrl_chk #(.AW(AW), .NW(NW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .op_pair(op_pair), .op_acc(op_acc), .busy(busy), .res_valid(res_valid),
  .ram_addr(ram_addr), .port_wr(port_wr), .port_rd(port_rd)
);

// File: tb/sim_nibble_mem_ctrl.sv
`timescale 1ns/1ps
module sim_nibble_mem_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [3:0] op_code = '0, op_acc = '0;
  logic [7:0] op_pair = '0;
  logic busy, res_valid, port_wr, port_rd;
  logic [3:0] res_data, port_wdata, port_rdata;
  logic [11:0] ram_addr;
  logic [5:0] port_addr;

  always #2 clk = ~clk;

  assign port_rdata = port_addr[3:0] ^ 4'h5;

  nibble_mem_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_pair(op_pair), .op_acc(op_acc), .busy(busy), .res_valid(res_valid),
    .res_data(res_data), .ram_addr(ram_addr), .port_addr(port_addr),
    .port_wr(port_wr), .port_rd(port_rd), .port_wdata(port_wdata),
    .port_rdata(port_rdata)
  );

  typedef struct { int kind; logic [5:0] a; logic [3:0] d; string req; } item_t;
  item_t q[$];
  int compared = 0, mismatched = 0;
  bit finished = 0;
  logic [11:0] m_addr = '0;
  logic [7:0] shadow [0:4095];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(int kind, logic [5:0] a, logic [3:0] d, string req);
    item_t it;
    it.kind = kind; it.a = a; it.d = d; it.req = req;
    q.push_back(it);
  endtask

  task automatic pop_cmp(int kind, logic [5:0] a, logic [3:0] d);
    item_t it;
    compared++;
    if (q.size() == 0) begin
      mismatched++;
      $display("FAIL unexpected event kind=%0d actual=%0h/%0h expected=none", kind, a, d);
    end else begin
      it = q.pop_front();
      if (it.kind != kind || it.a !== a || it.d !== d) begin
        mismatched++;
        $display("FAIL %s actual=%0d/%0h/%0h expected=%0d/%0h/%0h",
                 it.req, kind, a, d, it.kind, it.a, it.d);
      end
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (port_wr) pop_cmp(1, port_addr, port_wdata);
    if (port_rd) pop_cmp(2, port_addr, 4'h0);
    if (res_valid) pop_cmp(0, 6'h0, res_data);
  end

  task automatic issue(logic [3:0] code, logic [7:0] pair, logic [3:0] acc, string req);
    logic [11:0] ba;
    @(negedge clk);
    while (busy) @(negedge clk);
    ba = (code >= 4 && code <= 11) ? {m_addr[11:4], 2'b00, code[1:0]} : m_addr;
    case (code)
      4'd0: m_addr[7:0] = pair;
      4'd1: m_addr[11:8] = acc;
      4'd2: push(0, 6'h0, shadow[ba][3:0], req);
      4'd3: shadow[ba][3:0] = acc;
      4'd4, 4'd5, 4'd6, 4'd7: push(0, 6'h0, shadow[ba][7:4], req);
      4'd8, 4'd9, 4'd10, 4'd11: shadow[ba][7:4] = acc;
      4'd12: push(1, m_addr[11:6] | 6'h10, acc, req);
      4'd13: begin
        push(2, {2'b00, m_addr[7:4]}, 4'h0, req);
        push(0, 6'h0, m_addr[7:4] ^ 4'h5, req);
      end
      4'd14: push(1, {2'b00, m_addr[7:4]}, acc, req);
      default: ;
    endcase
    op_valid = 1'b1; op_code = code; op_pair = pair; op_acc = acc;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!finished) begin
      mismatched++; compared++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) shadow[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 addr", ram_addr, 12'h000);
    chk("R1 busy", busy, 0);
    chk("R1 strobes", {res_valid, port_wr, port_rd}, 3'b000);
    rst_n = 1'b1;

    issue(4'd0, 8'h5C, 4'h0, "R2");
    chk("R2 select", ram_addr, 12'h05C);
    issue(4'd1, 8'hFF, 4'hA, "R3");
    chk("R3 bank", ram_addr, 12'hA5C);
    issue(4'd0, 8'h32, 4'h0, "R2");
    chk("R2 keeps high", ram_addr, 12'hA32);

    issue(4'd3, 8'h00, 4'h3, "R5");
    issue(4'd10, 8'h00, 4'h6, "R7");
    issue(4'd2, 8'h00, 4'h0, "R7 keeps low nibble");
    issue(4'd6, 8'h00, 4'h0, "R6");
    issue(4'd3, 8'h00, 4'hE, "R5");
    issue(4'd6, 8'h00, 4'h0, "R5 keeps high nibble");
    issue(4'd2, 8'h00, 4'h0, "R4");

    issue(4'd0, 8'h3D, 4'h0, "R2");
    for (int n = 0; n < 4; n++) issue(4'd8 + 4'(n), 8'h00, 4'(n + 8), "R7");
    for (int n = 0; n < 4; n++) issue(4'd4 + 4'(n), 8'h00, 4'h0, "R6 masked base");
    issue(4'd2, 8'h00, 4'h0, "R4 full address");
    issue(4'd0, 8'h32, 4'h0, "R2");
    issue(4'd2, 8'h00, 4'h0, "R7 status write kept main");

    issue(4'd1, 8'h00, 4'h7, "R3");
    issue(4'd0, 8'hC5, 4'h0, "R2");
    issue(4'd3, 8'h00, 4'h1, "R5");
    issue(4'd11, 8'h00, 4'h9, "R7");
    issue(4'd7, 8'h00, 4'h0, "R6");

    issue(4'd12, 8'h00, 4'h7, "R8");
    issue(4'd1, 8'h00, 4'hA, "R3");
    issue(4'd12, 8'h00, 4'h2, "R8");
    issue(4'd0, 8'h31, 4'h0, "R2");
    issue(4'd14, 8'h00, 4'hC, "R10");
    issue(4'd13, 8'h00, 4'h0, "R9");
    issue(4'd0, 8'hF0, 4'h0, "R2");
    issue(4'd13, 8'h00, 4'h0, "R9");

    issue(4'd0, 8'h32, 4'h0, "R2");
    issue(4'd2, 8'h00, 4'h0, "R11 read under ignored op");
    chk("R11 busy high", busy, 1);
    op_valid = 1'b1; op_code = 4'd0; op_pair = 8'hFF;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    chk("R11 ignored select", ram_addr, 12'hA32);
    chk("R11 busy released", busy, 0);
    issue(4'd6, 8'h00, 4'h0, "R11 later access same byte");

    repeat (5) @(negedge clk);
    chk("R4 scoreboard drained", q.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule